// File: doc/BRIEF.md
# Rename History Buffer with Rollback

This block keeps an ordered log of register renames for an out-of-order core. Each time a destination register is renamed, the rename stage pushes one record: the instruction's sequence number, the architectural register, the physical register just allocated, and the physical register that held the mapping before. The log serves two purposes. On commit it frees the superseded registers. On a misprediction it rolls back the speculative mappings.

A commit request with sequence number C starts a walk from the oldest end. Every record numbered C or lower is retired, one per cycle, and its previous physical register goes back to the free list. A squash request with number S starts a walk from the youngest end. Every record numbered above S is undone, one per cycle. The map table entry for its architectural register is restored to the previous physical register, and the newly allocated register is freed. A freed register whose index lies at or above a configurable base (the special-register range) is also reported so that the scoreboard can mark it ready.

The block does not contain the map table, the free list or the scoreboard. It drives one free-list return, at most one map-restore write and at most one mark-ready request per cycle.

Top module: `rename_history_buf`

## Requirements
- R1: A push is accepted when push_valid and push_ready are both high in the same cycle. The record is stored behind all earlier records, and the buffer holds at most DEPTH records.
- R2: push_ready is low when DEPTH records are held, while an undo walk is active, and in any cycle with squash_valid high. A push offered while push_ready is low is dropped and never appears in any later walk.
- R3: After squash_valid is sampled with number S, a walk starts in the next cycle and removes one record per cycle, youngest first, as long as the youngest record's sequence number (unsigned compare) is greater than S. Each removal drives restore_valid with that record's architectural register and previous physical register, and drives free_valid with its new physical register.
- R4: During an undo removal whose new physical register is at or above SPECIAL_BASE, mark_valid is high and mark_preg carries that register. mark_valid is never high otherwise.
- R5: After commit_valid is sampled with number C, a walk starts in the next cycle and removes one record per cycle, oldest first, as long as the oldest record's sequence number (unsigned compare) is at most C. Each removal drives free_valid with the previous physical register. restore_valid stays low during this walk.
- R6: A commit whose oldest record is already numbered above C, or that arrives while the buffer is empty, removes nothing and produces no output. The kept record remains available to a later squash.
- R7: A squash on an empty buffer produces no output.
- R8: No record is removed in a cycle with squash_valid high. A commit_valid sampled while an undo walk is active, or together with squash_valid, is ignored.
- R9: A push and a commit retirement may occur in the same cycle. The pushed record joins the retirement walk if its number is at most C.
- R10: busy rises in the cycle after an accepted commit or squash request. It stays high until the cycle after the walk finds no record left to remove.
- R11: After reset the buffer is empty and idle: busy, free_valid, restore_valid and mark_valid are low, and push_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Rename record offered |
| push_seq | input | SEQ_W | Sequence number of the renaming instruction |
| push_areg | input | AREG_W | Architectural destination register |
| push_new_preg | input | PREG_W | Newly allocated physical register |
| push_prev_preg | input | PREG_W | Physical register previously mapped |
| push_ready | output | 1 | Buffer can accept a record this cycle |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Youngest surviving sequence number |
| free_valid | output | 1 | A physical register is returned to the free list |
| free_preg | output | PREG_W | Returned physical register |
| restore_valid | output | 1 | Map-table restore write |
| restore_areg | output | AREG_W | Architectural register to restore |
| restore_preg | output | PREG_W | Physical register to write back into the map |
| mark_valid | output | 1 | Mark a special-range register ready |
| mark_preg | output | PREG_W | Register to mark ready |
| busy | output | 1 | A commit or undo walk is in progress |

## Verification
The assertions assume several things about the surrounding pipeline. Pushed sequence numbers rise monotonically without wrapping. A squash number is never older than a number that has already been committed. Nothing is pushed while push_ready is low unless the caller expects it to be dropped. Under these assumptions a register never appears on the free-list port from both walks in one cycle, and the record count stays in range.

The stimulus uses strictly increasing sequence numbers. It issues squashes only at or after the committed point. It offers exactly one push against a full buffer, to show that the push is dropped. It also times commit and squash requests to collide with each other, and to collide with walks already in progress.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE   = 2'd0,
    WALK_RETIRE = 2'd1,
    WALK_UNDO   = 2'd2
  } walk_e;
endpackage

// File: rtl/rhb_store.sv
module rhb_store #(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 16,
  parameter int AREG_W = 5,
  parameter int PREG_W = 7,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic [SEQ_W-1:0]  push_seq,
  input  logic [AREG_W-1:0] push_areg,
  input  logic [PREG_W-1:0] push_new,
  input  logic [PREG_W-1:0] push_prev,
  input  logic              pop_old,
  input  logic              pop_young,
  output logic [SEQ_W-1:0]  old_seq,
  output logic [PREG_W-1:0] old_prev,
  output logic [SEQ_W-1:0]  yng_seq,
  output logic [AREG_W-1:0] yng_areg,
  output logic [PREG_W-1:0] yng_new,
  output logic [PREG_W-1:0] yng_prev,
  output logic              empty,
  output logic              full,
  output logic [CNT_W-1:0]  count
);
  // circular index arithmetic, valid for any DEPTH
  function automatic logic [PTR_W-1:0] ptr_up(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dn(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : p - PTR_W'(1);
  endfunction

  logic [SEQ_W-1:0]  seq_m  [DEPTH];
  logic [AREG_W-1:0] areg_m [DEPTH];
  logic [PREG_W-1:0] new_m  [DEPTH];
  logic [PREG_W-1:0] prev_m [DEPTH];

  logic [PTR_W-1:0] head_q, tail_q, yng_idx;
  logic [CNT_W-1:0] cnt_q;

  assign yng_idx  = ptr_dn(tail_q);
  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign count    = cnt_q;
  assign old_seq  = seq_m[head_q];
  assign old_prev = prev_m[head_q];
  assign yng_seq  = seq_m[yng_idx];
  assign yng_areg = areg_m[yng_idx];
  assign yng_new  = new_m[yng_idx];
  assign yng_prev = prev_m[yng_idx];

  always_ff @(posedge clk) begin
    if (push_en) begin
      seq_m[tail_q]  <= push_seq;
      areg_m[tail_q] <= push_areg;
      new_m[tail_q]  <= push_new;
      prev_m[tail_q] <= push_prev;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop_old)        head_q <= ptr_up(head_q);
      if (push_en)        tail_q <= ptr_up(tail_q);
      else if (pop_young) tail_q <= yng_idx;
      cnt_q <= cnt_q + CNT_W'(push_en) - CNT_W'(pop_old) - CNT_W'(pop_young);
    end
  end
endmodule

// File: rtl/rhb_walker.sv
module rhb_walker
  import rhb_pkg::*;
#(
  parameter int SEQ_W        = 16,
  parameter int AREG_W       = 5,
  parameter int PREG_W       = 7,
  parameter int SPECIAL_BASE = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              empty,
  input  logic              full,
  input  logic [SEQ_W-1:0]  old_seq,
  input  logic [PREG_W-1:0] old_prev,
  input  logic [SEQ_W-1:0]  yng_seq,
  input  logic [AREG_W-1:0] yng_areg,
  input  logic [PREG_W-1:0] yng_new,
  input  logic [PREG_W-1:0] yng_prev,
  output logic              pop_old,
  output logic              pop_young,
  output logic              free_valid,
  output logic [PREG_W-1:0] free_preg,
  output logic              restore_valid,
  output logic [AREG_W-1:0] restore_areg,
  output logic [PREG_W-1:0] restore_preg,
  output logic              mark_valid,
  output logic [PREG_W-1:0] mark_preg,
  output logic              busy,
  output logic              push_ready
);
  // a record is covered by a commit when its number does not exceed the target
  function automatic logic covered(input logic [SEQ_W-1:0] s, input logic [SEQ_W-1:0] t);
    return s <= t;
  endfunction

  // a record is beyond a squash point when strictly younger
  function automatic logic beyond(input logic [SEQ_W-1:0] s, input logic [SEQ_W-1:0] t);
    return s > t;
  endfunction

  function automatic logic special_reg(input logic [PREG_W-1:0] p);
    return int'(p) >= SPECIAL_BASE;
  endfunction

  walk_e            mode_q;
  logic [SEQ_W-1:0] tgt_q;
  logic             undo_step, retire_step;

  assign undo_step   = (mode_q == WALK_UNDO) && !squash_valid && !empty && beyond(yng_seq, tgt_q);
  assign retire_step = (mode_q == WALK_RETIRE) && !squash_valid && !empty && covered(old_seq, tgt_q);

  assign pop_young     = undo_step;
  assign pop_old       = retire_step;
  assign free_valid    = undo_step || retire_step;
  assign free_preg     = undo_step ? yng_new : old_prev;
  assign restore_valid = undo_step;
  assign restore_areg  = yng_areg;
  assign restore_preg  = yng_prev;
  assign mark_valid    = undo_step && special_reg(yng_new);
  assign mark_preg     = yng_new;
  assign busy          = (mode_q != WALK_IDLE);
  assign push_ready    = !full && (mode_q != WALK_UNDO) && !squash_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= WALK_IDLE;
      tgt_q  <= '0;
    end else if (squash_valid) begin
      mode_q <= WALK_UNDO;
      tgt_q  <= squash_seq;
    end else if (mode_q == WALK_UNDO) begin
      if (!undo_step) mode_q <= WALK_IDLE;
    end else if (commit_valid) begin
      mode_q <= WALK_RETIRE;
      tgt_q  <= commit_seq;
    end else if (mode_q == WALK_RETIRE && !retire_step) begin
      mode_q <= WALK_IDLE;
    end
  end
endmodule

// File: rtl/rename_history_buf.sv
module rename_history_buf #(
  parameter int DEPTH        = 16,
  parameter int SEQ_W        = 16,
  parameter int AREG_W       = 5,
  parameter int PREG_W       = 7,
  parameter int SPECIAL_BASE = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [SEQ_W-1:0]  push_seq,
  input  logic [AREG_W-1:0] push_areg,
  input  logic [PREG_W-1:0] push_new_preg,
  input  logic [PREG_W-1:0] push_prev_preg,
  output logic              push_ready,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  output logic              free_valid,
  output logic [PREG_W-1:0] free_preg,
  output logic              restore_valid,
  output logic [AREG_W-1:0] restore_areg,
  output logic [PREG_W-1:0] restore_preg,
  output logic              mark_valid,
  output logic [PREG_W-1:0] mark_preg,
  output logic              busy
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  // internal events, named for the checker
  logic              push_acc, pop_old, pop_young, store_empty, store_full;
  logic [CNT_W-1:0]  rec_count;
  logic [SEQ_W-1:0]  old_seq, yng_seq;
  logic [PREG_W-1:0] old_prev, yng_new, yng_prev;
  logic [AREG_W-1:0] yng_areg;

  assign push_acc = push_valid && push_ready;

  rhb_store #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .push_en(push_acc), .push_seq(push_seq), .push_areg(push_areg),
    .push_new(push_new_preg), .push_prev(push_prev_preg),
    .pop_old(pop_old), .pop_young(pop_young),
    .old_seq(old_seq), .old_prev(old_prev),
    .yng_seq(yng_seq), .yng_areg(yng_areg), .yng_new(yng_new), .yng_prev(yng_prev),
    .empty(store_empty), .full(store_full), .count(rec_count)
  );

  rhb_walker #(
    .SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W), .SPECIAL_BASE(SPECIAL_BASE)
  ) u_walk (
    .clk(clk), .rst_n(rst_n),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .empty(store_empty), .full(store_full),
    .old_seq(old_seq), .old_prev(old_prev),
    .yng_seq(yng_seq), .yng_areg(yng_areg), .yng_new(yng_new), .yng_prev(yng_prev),
    .pop_old(pop_old), .pop_young(pop_young),
    .free_valid(free_valid), .free_preg(free_preg),
    .restore_valid(restore_valid), .restore_areg(restore_areg), .restore_preg(restore_preg),
    .mark_valid(mark_valid), .mark_preg(mark_preg),
    .busy(busy), .push_ready(push_ready)
  );
endmodule

// File: rtl/rhb_checker.sv
module rhb_checker #(
  parameter int DEPTH        = 16,
  parameter int PREG_W       = 7,
  parameter int SPECIAL_BASE = 96,
  parameter int CNT_W        = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_ready,
  input logic              squash_valid,
  input logic              free_valid,
  input logic [PREG_W-1:0] free_preg,
  input logic              restore_valid,
  input logic              mark_valid,
  input logic [PREG_W-1:0] mark_preg,
  input logic              busy,
  input logic [CNT_W-1:0]  rec_count,
  input logic              store_full,
  input logic              push_acc,
  input logic              pop_old,
  input logic              pop_young
);
  AST_FULL_BLOCKS_PUSH: assert property (@(posedge clk) disable iff (!rst_n) store_full |-> !push_ready); // R2
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) int'(rec_count) <= DEPTH); // R1
  AST_NO_PUSH_IN_UNDO: assert property (@(posedge clk) disable iff (!rst_n) !(push_acc && pop_young)); // R2
  AST_ONE_END_ONLY: assert property (@(posedge clk) disable iff (!rst_n) !(pop_old && pop_young)); // R8
  AST_RESTORE_FREES: assert property (@(posedge clk) disable iff (!rst_n) restore_valid |-> free_valid); // R3
  AST_RETIRE_NO_RESTORE: assert property (@(posedge clk) disable iff (!rst_n) pop_old |-> !restore_valid); // R5
  AST_MARK_ON_UNDO: assert property (@(posedge clk) disable iff (!rst_n)
    mark_valid |-> (restore_valid && mark_preg == free_preg && int'(mark_preg) >= SPECIAL_BASE)); // R4
  AST_SQUASH_QUIET: assert property (@(posedge clk) disable iff (!rst_n) squash_valid |-> !free_valid); // R8
  AST_SQUASH_BUSY: assert property (@(posedge clk) disable iff (!rst_n) squash_valid |=> busy); // R10
endmodule

bind rename_history_buf rhb_checker #(
  .DEPTH(DEPTH), .PREG_W(PREG_W), .SPECIAL_BASE(SPECIAL_BASE), .CNT_W($clog2(DEPTH + 1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .push_ready(push_ready), .squash_valid(squash_valid),
  .free_valid(free_valid), .free_preg(free_preg), .restore_valid(restore_valid),
  .mark_valid(mark_valid), .mark_preg(mark_preg), .busy(busy),
  .rec_count(rec_count), .store_full(store_full), .push_acc(push_acc),
  .pop_old(pop_old), .pop_young(pop_young)
);

// File: tb/rename_history_buf_test.sv
`timescale 1ns/1ps
module rename_history_buf_test;
  localparam int DEPTH = 4, SEQ_W = 8, AREG_W = 5, PREG_W = 7, BASE = 96;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_valid = 1'b0, commit_valid = 1'b0, squash_valid = 1'b0;
  logic [SEQ_W-1:0] push_seq = '0, commit_seq = '0, squash_seq = '0;
  logic [AREG_W-1:0] push_areg = '0;
  logic [PREG_W-1:0] push_new_preg = '0, push_prev_preg = '0;
  logic push_ready, free_valid, restore_valid, mark_valid, busy;
  logic [PREG_W-1:0] free_preg, restore_preg, mark_preg;
  logic [AREG_W-1:0] restore_areg;

  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  rename_history_buf #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W),
                       .SPECIAL_BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_seq(push_seq),
    .push_areg(push_areg), .push_new_preg(push_new_preg), .push_prev_preg(push_prev_preg),
    .push_ready(push_ready), .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq), .free_valid(free_valid),
    .free_preg(free_preg), .restore_valid(restore_valid), .restore_areg(restore_areg),
    .restore_preg(restore_preg), .mark_valid(mark_valid), .mark_preg(mark_preg), .busy(busy)
  );

  typedef struct packed {
    bit pv; bit [7:0] ps; bit [4:0] pa; bit [6:0] pn; bit [6:0] pp;
    bit cv; bit [7:0] cs; bit sv; bit [7:0] ss;
    bit efv; bit [6:0] ef; bit erv; bit [4:0] era; bit [6:0] erp;
    bit emv; bit eb; bit er;
  } vec_t;

  // fields: push(v,seq,areg,new,prev) commit(v,seq) squash(v,seq)
  //         expect free(v,preg) restore(v,areg,preg) mark_v busy push_ready
  localparam vec_t VEC [40] = '{
    '{1,10,1,40,1,   0,0,0,0,  0,0,0,0,0,0,0,1},  // 0  R1 push
    '{1,12,2,41,2,   0,0,0,0,  0,0,0,0,0,0,0,1},  // 1
    '{1,14,3,42,3,   0,0,0,0,  0,0,0,0,0,0,0,1},  // 2
    '{1,16,1,100,40, 0,0,0,0,  0,0,0,0,0,0,0,1},  // 3  fills buffer
    '{1,18,5,50,5,   0,0,0,0,  0,0,0,0,0,0,0,0},  // 4  R2 dropped while full
    '{0,0,0,0,0,     1,12,0,0, 0,0,0,0,0,0,0,0},  // 5  commit 12
    '{0,0,0,0,0,     0,0,0,0,  1,1,0,0,0,0,1,0},  // 6  R5 retire seq 10
    '{0,0,0,0,0,     0,0,0,0,  1,2,0,0,0,0,1,1},  // 7  retire seq 12
    '{0,0,0,0,0,     0,0,0,0,  0,0,0,0,0,0,1,1},  // 8  seq 14 not covered
    '{1,20,4,43,4,   0,0,0,0,  0,0,0,0,0,0,0,1},  // 9  R10 idle again
    '{0,0,0,0,0,     1,20,1,14,0,0,0,0,0,0,0,0},  // 10 R8 squash wins over commit
    '{0,0,0,0,0,     1,20,0,0, 1,43,1,4,4,0,1,0}, // 11 R3 undo 20; commit ignored
    '{0,0,0,0,0,     0,0,0,0,  1,100,1,1,40,1,1,0},// 12 R4 undo 16, special reg
    '{0,0,0,0,0,     0,0,0,0,  0,0,0,0,0,0,1,0},  // 13 seq 14 survives
    '{0,0,0,0,0,     1,14,0,0, 0,0,0,0,0,0,0,1},  // 14
    '{0,0,0,0,0,     0,0,0,0,  1,3,0,0,0,0,1,1},  // 15 retire 14 (18 never stored)
    '{0,0,0,0,0,     0,0,0,0,  0,0,0,0,0,0,1,1},  // 16 empty
    '{0,0,0,0,0,     1,30,0,0, 0,0,0,0,0,0,0,1},  // 17 R6 commit on empty
    '{0,0,0,0,0,     0,0,0,0,  0,0,0,0,0,0,1,1},  // 18
    '{0,0,0,0,0,     0,0,1,5,  0,0,0,0,0,0,0,0},  // 19 R7 squash on empty
    '{0,0,0,0,0,     0,0,0,0,  0,0,0,0,0,0,1,0},  // 20
    '{1,50,5,44,5,   0,0,0,0,  0,0,0,0,0,0,0,1},  // 21
    '{1,52,6,45,6,   1,60,0,0, 0,0,0,0,0,0,0,1},  // 22
    '{1,54,7,46,7,   0,0,0,0,  1,5,0,0,0,0,1,1},  // 23 R9 push with retire
    '{0,0,0,0,0,     0,0,0,0,  1,6,0,0,0,0,1,1},  // 24
    '{0,0,0,0,0,     0,0,0,0,  1,7,0,0,0,0,1,1},  // 25 pushed record retired
    '{0,0,0,0,0,     0,0,0,0,  0,0,0,0,0,0,1,1},  // 26
    '{1,70,10,47,10, 0,0,0,0,  0,0,0,0,0,0,0,1},  // 27
    '{0,0,0,0,0,     1,65,0,0, 0,0,0,0,0,0,0,1},  // 28 R6 oldest younger than C
    '{0,0,0,0,0,     0,0,0,0,  0,0,0,0,0,0,1,1},  // 29
    '{0,0,0,0,0,     0,0,1,69, 0,0,0,0,0,0,0,0},  // 30
    '{0,0,0,0,0,     0,0,0,0,  1,47,1,10,10,0,1,0},// 31 kept record undone
    '{0,0,0,0,0,     0,0,0,0,  0,0,0,0,0,0,1,0},  // 32
    '{1,80,8,48,8,   0,0,0,0,  0,0,0,0,0,0,0,1},  // 33
    '{1,82,9,49,9,   1,90,0,0, 0,0,0,0,0,0,0,1},  // 34
    '{0,0,0,0,0,     0,0,1,79, 0,0,0,0,0,0,1,0},  // 35 R8 retire held off
    '{0,0,0,0,0,     0,0,0,0,  1,49,1,9,9,0,1,0}, // 36
    '{0,0,0,0,0,     0,0,0,0,  1,48,1,8,8,0,1,0}, // 37
    '{0,0,0,0,0,     0,0,0,0,  0,0,0,0,0,0,1,0},  // 38
    '{0,0,0,0,0,     0,0,0,0,  0,0,0,0,0,0,0,1}   // 39
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    push_valid = 0; commit_valid = 0; squash_valid = 0;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R11 reset state
    chk("R11 busy after reset", busy, 0);
    chk("R11 push_ready after reset", push_ready, 1);
    chk("R11 free_valid after reset", free_valid, 0);
    chk("R11 restore_valid after reset", restore_valid, 0);
    chk("R11 mark_valid after reset", mark_valid, 0);

    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      push_valid = VEC[i].pv; push_seq = VEC[i].ps; push_areg = VEC[i].pa;
      push_new_preg = VEC[i].pn; push_prev_preg = VEC[i].pp;
      commit_valid = VEC[i].cv; commit_seq = VEC[i].cs;
      squash_valid = VEC[i].sv; squash_seq = VEC[i].ss;
      #1;
      chk($sformatf("R3 R5 R9 free_valid row %0d", i), free_valid, VEC[i].efv);
      if (VEC[i].efv) chk($sformatf("R3 R5 free_preg row %0d", i), free_preg, VEC[i].ef);
      chk($sformatf("R3 R6 R7 restore_valid row %0d", i), restore_valid, VEC[i].erv);
      if (VEC[i].erv) begin
        chk($sformatf("R3 restore_areg row %0d", i), restore_areg, VEC[i].era);
        chk($sformatf("R3 restore_preg row %0d", i), restore_preg, VEC[i].erp);
      end
      chk($sformatf("R4 mark_valid row %0d", i), mark_valid, VEC[i].emv);
      if (VEC[i].emv) chk($sformatf("R4 mark_preg row %0d", i), mark_preg, VEC[i].ef);
      chk($sformatf("R10 busy row %0d", i), busy, VEC[i].eb);
      chk($sformatf("R2 R8 push_ready row %0d", i), push_ready, VEC[i].er);
    end

    // R11: reset in mid-operation discards held records
    @(negedge clk); idle_inputs();
    push_valid = 1; push_seq = 100; push_areg = 2; push_new_preg = 60; push_prev_preg = 2;
    @(negedge clk); push_seq = 101; push_new_preg = 61;
    @(negedge clk); idle_inputs(); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R11 busy after mid-run reset", busy, 0);
    chk("R11 push_ready after mid-run reset", push_ready, 1);
    @(negedge clk); squash_valid = 1; squash_seq = 0;
    @(negedge clk); idle_inputs();
    #1;
    chk("R7 R11 nothing undone after reset", restore_valid, 0);
    chk("R7 R11 nothing freed after reset", free_valid, 0);
    chk("R10 busy during empty undo", busy, 1);
    @(negedge clk); #1;
    chk("R10 busy drops", busy, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule